// File: doc/BRIEF.md
# Offset and Gain Calibration Controller

This block closes a digital trim loop around an imaging ADC. It drives two external trim DACs, one for offset and one for fine gain, through a parallel value bus with a one-cycle write strobe and a select bit. It watches each valid ADC sample, which is a straight-binary code together with an out-of-range flag that shares the code's pipeline delay. The operator first presents a dark input. The controller trims offset until the code sits on zero with its LSB flickering. It then asks for a saturated input through its phase output and trims gain until the code sits on all ones with its LSB flickering.

Each trim runs a binary search from mid-scale. The step starts at a quarter of the DAC range and halves after every move, but never drops below one. After every DAC write the controller lets a programmable number of samples pass before it judges the output. A candidate setting is accepted only after a window of samples stays on the target code pair and shows both LSB values. If the search needs to move past a DAC rail, the controller flags an error and stops.

Top module: `cal_trim_ctrl`

## Requirements
- R1: Gain trimming starts only after offset has converged. While the offset phase runs (busy_o=1, gain_phase_o=0), gain_dac_o stays at mid-scale (2^(DAC_W-1)) and no write with dac_sel_o=1 is issued.
- R2: Range decode: under_o = oor & ~code[MSB] and over_o = oor & code[MSB], with oor=0 meaning in range. Both are registered one cycle after a sample with smp_vld_i=1 and hold when smp_vld_i=0.
- R3: The offset phase ends with the offset DAC at the setting whose samples are code 0 or 1 in range. Underrange, or an in-range code above 1, moves the offset DAC up or down respectively. Overrange moves it down.
- R4: The gain phase ends with the gain DAC at the setting whose samples are 0x3FFE or 0x3FFF in range. Overrange moves the gain DAC down. Underrange, or an in-range code below 0x3FFE, moves it up.
- R5: After each DAC write the first SETTLE_SAMP valid samples are disregarded, and the decision uses the next valid sample.
- R6: A setting is accepted only after WIN_SAMP further samples all stay in the target pair and include both LSB values. If all of them show LSB 0 the DAC moves up, and if all show LSB 1 it moves down.
- R7: If a move is needed beyond code 0 or the maximum code of the active DAC, err_o rises, busy_o falls and no further DAC write occurs until start_i.
- R8: After reset both DACs are at mid-scale and busy_o, done_o, err_o and dac_wr_o are 0. start_i, when the block is not busy, restarts calibration from mid-scale, including from the done or error state.
- R9: dac_wr_o is a single-cycle pulse. The new value is already on the selected DAC output during that cycle, and dac_sel_o equals gain_phase_o.
- R10: The first search move from mid-scale is 2^(DAC_W-2) codes. Each later move halves the step, with a minimum of one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration run |
| smp_vld_i | input | 1 | ADC sample valid strobe |
| smp_code_i | input | CODE_W | ADC straight-binary output code |
| smp_oor_i | input | 1 | ADC out-of-range flag |
| ofs_dac_o | output | DAC_W | Offset trim DAC value |
| gain_dac_o | output | DAC_W | Fine gain trim DAC value |
| dac_wr_o | output | 1 | DAC write strobe |
| dac_sel_o | output | 1 | Write target: 0 offset, 1 gain |
| gain_phase_o | output | 1 | 1 while the gain phase runs (saturated input requested) |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Both trims converged |
| err_o | output | 1 | A trim hit a DAC rail |
| over_o | output | 1 | Last sample was overrange |
| under_o | output | 1 | Last sample was underrange |

## Verification
The bench builds the block with a 10-bit DAC, a settle count of 3 and an 8-sample window. A 10-bit DAC lets a run of a few hundred cycles reach both rails, which covers the error path on the offset trim and on the gain trim. The ADC model returns deliberate overrange garbage for exactly three samples after each write, so a controller that judges too early drifts down and fails. With an 8-sample window, a target whose LSB never toggles can be shown to block convergence within a short run.

// File: rtl/cal_ctl_pkg.sv
package cal_ctl_pkg;
   typedef enum logic [2:0] {
      CS_IDLE, CS_SETTLE, CS_EVAL, CS_WINDOW, CS_DONE, CS_FAIL
   } cal_state_e;

   typedef enum logic [1:0] {
      MV_NONE, MV_UP, MV_DOWN, MV_HIT
   } cal_move_e;
endpackage

// File: rtl/cal_sample_judge.sv
module cal_sample_judge
   import cal_ctl_pkg::*;
#(
   parameter int CODE_W = 14
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              oor_i,
   input  logic              gain_ph_i,
   output logic              under_o,
   output logic              over_o,
   output cal_move_e         move_o
);
   localparam int PAIR_W = CODE_W - 1;

   logic [PAIR_W-1:0] pair;
   assign pair    = code_i[CODE_W-1:1];
   assign under_o = oor_i & ~code_i[CODE_W-1];
   assign over_o  = oor_i &  code_i[CODE_W-1];

   always_comb begin
      if (!gain_ph_i) begin
         if (under_o)          move_o = MV_UP;
         else if (over_o)      move_o = MV_DOWN;
         else if (pair == '0)  move_o = MV_HIT;
         else                  move_o = MV_DOWN;
      end else begin
         if (over_o)           move_o = MV_DOWN;
         else if (under_o)     move_o = MV_UP;
         else if (&pair)       move_o = MV_HIT;
         else                  move_o = MV_UP;
      end
   end
endmodule

// File: rtl/cal_trim_step.sv
module cal_trim_step #(
   parameter int DAC_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic             en_i,
   input  logic             up_i,
   input  logic             dn_i,
   output logic [DAC_W-1:0] dac_o,
   output logic             at_top_o,
   output logic             at_bot_o
);
   localparam logic [DAC_W-1:0] MIDV  = DAC_W'(1) << (DAC_W - 1);
   localparam logic [DAC_W-1:0] MAXV  = '1;
   localparam logic [DAC_W-1:0] STEP0 = DAC_W'(1) << (DAC_W - 2);

   logic [DAC_W-1:0] step_q, step_n;

   assign step_n   = (step_q > DAC_W'(1)) ? (step_q >> 1) : DAC_W'(1);
   assign at_top_o = (dac_o == MAXV);
   assign at_bot_o = (dac_o == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dac_o  <= MIDV;
         step_q <= STEP0;
      end else if (init_i) begin
         dac_o  <= MIDV;
         step_q <= STEP0;
      end else if (en_i && up_i) begin
         dac_o  <= (dac_o > MAXV - step_q) ? MAXV : dac_o + step_q;
         step_q <= step_n;
      end else if (en_i && dn_i) begin
         dac_o  <= (dac_o < step_q) ? '0 : dac_o - step_q;
         step_q <= step_n;
      end
   end
endmodule

// File: rtl/cal_dither_win.sv
module cal_dither_win #(
   parameter int WIN_SAMP = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic push_i,
   input  logic lsb_i,
   output logic last_o,
   output logic toggled_o,
   output logic low_only_o
);
   localparam int WC = $clog2(WIN_SAMP + 1);

   logic [WC-1:0] cnt_q;
   logic          seen0_q, seen1_q;
   logic          seen0_n, seen1_n;

   assign seen0_n    = seen0_q | ~lsb_i;
   assign seen1_n    = seen1_q |  lsb_i;
   assign last_o     = (cnt_q == WC'(WIN_SAMP - 1));
   assign toggled_o  = seen0_n & seen1_n;
   assign low_only_o = ~seen1_n;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         seen0_q <= 1'b0;
         seen1_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q   <= '0;
         seen0_q <= 1'b0;
         seen1_q <= 1'b0;
      end else if (push_i) begin
         cnt_q   <= cnt_q + WC'(1);
         seen0_q <= seen0_n;
         seen1_q <= seen1_n;
      end
   end
endmodule

// File: rtl/cal_trim_ctrl.sv
module cal_trim_ctrl
   import cal_ctl_pkg::*;
#(
   parameter int CODE_W      = 14,
   parameter int DAC_W       = 10,
   parameter int SETTLE_SAMP = 3,
   parameter int WIN_SAMP    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              smp_vld_i,
   input  logic [CODE_W-1:0] smp_code_i,
   input  logic              smp_oor_i,
   output logic [DAC_W-1:0]  ofs_dac_o,
   output logic [DAC_W-1:0]  gain_dac_o,
   output logic              dac_wr_o,
   output logic              dac_sel_o,
   output logic              gain_phase_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              over_o,
   output logic              under_o
);
   localparam int SCW = $clog2(SETTLE_SAMP + 1);

   if (CODE_W < 4)       begin : g_bad_code   $error("CODE_W must be at least 4");      end
   if (DAC_W < 2)        begin : g_bad_dac    $error("DAC_W must be at least 2");       end
   if (SETTLE_SAMP < 1)  begin : g_bad_settle $error("SETTLE_SAMP must be at least 1"); end
   if (WIN_SAMP < 2)     begin : g_bad_win    $error("WIN_SAMP must be at least 2");    end

   cal_state_e       state_q;
   logic             gain_ph_q;
   logic [SCW-1:0]   scnt_q;
   cal_move_e        mv;
   logic             smp_under, smp_over;
   logic             win_last, win_tog, win_low;
   logic             idle_like, start_go, judging;
   logic             want_up, want_dn, rail_hit, move_go;
   logic             win_clear, win_push, phase_ok;
   logic [1:0][DAC_W-1:0] trim_dac;
   logic [1:0]       trim_top, trim_bot;
   logic             act_top, act_bot;

   cal_sample_judge #(.CODE_W(CODE_W)) u_judge (
      .code_i   (smp_code_i),
      .oor_i    (smp_oor_i),
      .gain_ph_i(gain_ph_q),
      .under_o  (smp_under),
      .over_o   (smp_over),
      .move_o   (mv)
   );

   cal_dither_win #(.WIN_SAMP(WIN_SAMP)) u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (win_clear),
      .push_i    (win_push),
      .lsb_i     (smp_code_i[0]),
      .last_o    (win_last),
      .toggled_o (win_tog),
      .low_only_o(win_low)
   );

   for (genvar g = 0; g < 2; g++) begin : g_trim
      cal_trim_step #(.DAC_W(DAC_W)) u_trim (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .init_i  (start_go),
         .en_i    (move_go && (gain_ph_q == 1'(g))),
         .up_i    (want_up),
         .dn_i    (want_dn),
         .dac_o   (trim_dac[g]),
         .at_top_o(trim_top[g]),
         .at_bot_o(trim_bot[g])
      );
   end

   assign idle_like = (state_q == CS_IDLE) || (state_q == CS_DONE) || (state_q == CS_FAIL);
   assign start_go  = start_i && idle_like;
   assign judging   = smp_vld_i && ((state_q == CS_EVAL) || (state_q == CS_WINDOW));
   assign act_top   = gain_ph_q ? trim_top[1] : trim_top[0];
   assign act_bot   = gain_ph_q ? trim_bot[1] : trim_bot[0];

   always_comb begin
      want_up = 1'b0;
      want_dn = 1'b0;
      if (judging) begin
         if (mv == MV_UP)        want_up = 1'b1;
         else if (mv == MV_DOWN) want_dn = 1'b1;
         else if (mv == MV_HIT && state_q == CS_WINDOW && win_last && !win_tog) begin
            want_up = win_low;
            want_dn = ~win_low;
         end
      end
   end

   assign rail_hit  = (want_up && act_top) || (want_dn && act_bot);
   assign move_go   = (want_up || want_dn) && !rail_hit;
   assign win_clear = judging && (state_q == CS_EVAL) && (mv == MV_HIT);
   assign win_push  = judging && (state_q == CS_WINDOW) && (mv == MV_HIT);
   assign phase_ok  = win_push && win_last && win_tog;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= CS_IDLE;
         gain_ph_q <= 1'b0;
         scnt_q    <= '0;
         dac_wr_o  <= 1'b0;
         dac_sel_o <= 1'b0;
         over_o    <= 1'b0;
         under_o   <= 1'b0;
      end else begin
         dac_wr_o <= 1'b0;
         if (smp_vld_i) begin
            over_o  <= smp_over;
            under_o <= smp_under;
         end
         if (start_go) begin
            state_q   <= CS_SETTLE;
            gain_ph_q <= 1'b0;
            scnt_q    <= '0;
            dac_wr_o  <= 1'b1;
            dac_sel_o <= 1'b0;
         end else if (state_q == CS_SETTLE) begin
            if (smp_vld_i) begin
               if (scnt_q == SCW'(SETTLE_SAMP - 1)) begin
                  state_q <= CS_EVAL;
                  scnt_q  <= '0;
               end else begin
                  scnt_q <= scnt_q + SCW'(1);
               end
            end
         end else if (judging) begin
            if (rail_hit) begin
               state_q <= CS_FAIL;
            end else if (move_go) begin
               state_q   <= CS_SETTLE;
               dac_wr_o  <= 1'b1;
               dac_sel_o <= gain_ph_q;
            end else if (win_clear) begin
               state_q <= CS_WINDOW;
            end else if (phase_ok) begin
               if (!gain_ph_q) begin
                  gain_ph_q <= 1'b1;
                  state_q   <= CS_SETTLE;
                  dac_wr_o  <= 1'b1;
                  dac_sel_o <= 1'b1;
               end else begin
                  state_q <= CS_DONE;
               end
            end
         end
      end
   end

   assign ofs_dac_o    = trim_dac[0];
   assign gain_dac_o   = trim_dac[1];
   assign gain_phase_o = gain_ph_q;
   assign busy_o       = !idle_like;
   assign done_o       = (state_q == CS_DONE);
   assign err_o        = (state_q == CS_FAIL);
endmodule

// File: rtl/cal_trim_ctrl_chk.sv
module cal_trim_ctrl_chk #(
   parameter int DAC_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic [DAC_W-1:0] ofs_dac_o,
   input logic [DAC_W-1:0] gain_dac_o,
   input logic             dac_wr_o,
   input logic             dac_sel_o,
   input logic             gain_phase_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o,
   input logic             over_o,
   input logic             under_o
);
   localparam logic [DAC_W-1:0] MIDV = DAC_W'(1) << (DAC_W - 1);

   assert_gain_parked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !gain_phase_o) |-> (gain_dac_o == MIDV));

   assert_range_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({over_o, under_o}));

   assert_fail_latched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !start_i) |=> (err_o && !dac_wr_o));

   assert_status_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({busy_o, done_o, err_o}));

   assert_wr_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_wr_o |=> !dac_wr_o);

   assert_wr_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_wr_o |-> (dac_sel_o == gain_phase_o));

   assert_ofs_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ofs_dac_o) |-> (dac_wr_o && !dac_sel_o));

   assert_gain_change_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(gain_dac_o) |-> (dac_wr_o && (dac_sel_o || !gain_phase_o)));
endmodule

bind cal_trim_ctrl cal_trim_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .ofs_dac_o   (ofs_dac_o),
   .gain_dac_o  (gain_dac_o),
   .dac_wr_o    (dac_wr_o),
   .dac_sel_o   (dac_sel_o),
   .gain_phase_o(gain_phase_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .over_o      (over_o),
   .under_o     (under_o)
);

// File: tb/cal_trim_ctrl_tb_top.sv
module cal_trim_ctrl_tb_top;
   localparam int CODE_W = 14;
   localparam int DAC_W  = 10;
   localparam int SETTLE = 3;
   localparam int WIN    = 8;
   localparam int MIDV   = 1 << (DAC_W - 1);
   localparam int STEP0  = 1 << (DAC_W - 2);
   localparam int TOPC   = (1 << CODE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic vld = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic oor = 1'b0;
   logic [DAC_W-1:0] ofs_dac, gain_dac;
   logic dac_wr, dac_sel, gain_ph, busy, done, err, over, under;

   int n_checks = 0;
   int n_fail = 0;
   bit stuck_lsb = 1'b0;

   always #2 clk = ~clk;

   cal_trim_ctrl #(.CODE_W(CODE_W), .DAC_W(DAC_W), .SETTLE_SAMP(SETTLE), .WIN_SAMP(WIN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .smp_vld_i(vld),
      .smp_code_i(code), .smp_oor_i(oor), .ofs_dac_o(ofs_dac), .gain_dac_o(gain_dac),
      .dac_wr_o(dac_wr), .dac_sel_o(dac_sel), .gain_phase_o(gain_ph), .busy_o(busy),
      .done_o(done), .err_o(err), .over_o(over), .under_o(under));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ADC model: offset phase aims at code 0/1, gain phase at 3FFE/3FFF
   function automatic void model(input int dac, input int tgt, input bit gph,
                                 output logic [CODE_W-1:0] c, output logic o);
      int d = dac - tgt;
      int lsb = stuck_lsb ? 0 : int'($urandom_range(1, 0));
      o = 1'b0;
      if (!gph) begin
         if (d < 0)       begin o = 1'b1; c = '0; end
         else if (d == 0) c = CODE_W'(lsb);
         else             c = CODE_W'((d * 3 + 1 > TOPC) ? TOPC : d * 3 + 1);
      end else begin
         if (d > 0)       begin o = 1'b1; c = '1; end
         else if (d == 0) c = CODE_W'(TOPC - 1 + lsb);
         else             c = CODE_W'(TOPC - 1 + 2 * d);
      end
   endfunction

   task automatic run_cal(input int to, input int tg, input int limit,
                          output int first_move, output int leak, output int doubles);
      int post_wr = 0;
      int ofs_wr = 0;
      bit prev_wr = 1'b0;
      first_move = -1; leak = 0; doubles = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int cyc = 0; cyc < limit; cyc++) begin
         if (cyc > 0) @(negedge clk);
         if (busy && !gain_ph && gain_dac != DAC_W'(MIDV)) leak++;
         if (dac_wr && dac_sel && !gain_ph) leak++;
         if (dac_wr && prev_wr) doubles++;
         prev_wr = dac_wr;
         if (dac_wr) begin
            post_wr = 0;
            if (!dac_sel) begin
               ofs_wr++;
               if (ofs_wr == 2) first_move = int'(ofs_dac);
            end
         end
         if (done || err) break;
         vld = ($urandom_range(9, 0) < 7);
         if (vld) begin
            post_wr++;
            if (post_wr <= SETTLE) begin oor = 1'b1; code = '1; end
            else model(gain_ph ? int'(gain_dac) : int'(ofs_dac), gain_ph ? tg : to, gain_ph, code, oor);
         end
      end
      vld = 1'b0;
   endtask

   task automatic cal_case(input int to, input int tg, input bit exp_err, input string tag);
      int fm, lk, db, exp_fm;
      run_cal(to, tg, 30000, fm, lk, db);
      if (!exp_err) begin
         chk(done && !err, {tag, " R3 R4 done"}, int'(done), 1);
         chk(int'(ofs_dac) == to, {tag, " R3 offset trim"}, int'(ofs_dac), to);
         chk(int'(gain_dac) == tg, {tag, " R4 gain trim"}, int'(gain_dac), tg);
      end else begin
         chk(err && !done && !busy, {tag, " R7 error stop"}, int'(err), 1);
      end
      chk(lk == 0, {tag, " R1 gain untouched in offset phase"}, lk, 0);
      chk(db == 0, {tag, " R9 single-cycle strobe"}, db, 0);
      exp_fm = (to > MIDV) ? MIDV + STEP0 : (to < MIDV) ? MIDV - STEP0 : -1;
      chk(fm == exp_fm, {tag, " R10 R5 first search move"}, fm, exp_fm);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(int'(ofs_dac) == MIDV && int'(gain_dac) == MIDV, "R8 reset DAC mid", int'(ofs_dac), MIDV);
      chk(!busy && !done && !err && !dac_wr, "R8 reset status", int'({busy, done, err, dac_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !dac_wr, "R8 idle after reset", int'({busy, done, err, dac_wr}), 0);

      // R2 range decode, directed
      for (int k = 0; k < 4; k++) begin
         vld = 1'b1; oor = k[1]; code = {k[0], {(CODE_W-1){1'b0}}};
         @(negedge clk);
         chk(under == (k[1] & ~k[0]) && over == (k[1] & k[0]), "R2 decode",
             int'({over, under}), int'({k[1] & k[0], k[1] & ~k[0]}));
      end
      vld = 1'b0; oor = 1'b0; code = '0;
      @(negedge clk);
      chk(over && !under, "R2 hold without valid", int'({over, under}), 2);
      for (int k = 0; k < 4; k++) begin
         code = {1'b0, {(CODE_W-1){1'b1}}}; oor = 1'b1; vld = 1'b1;
         @(negedge clk);
         chk(under && !over, "R2 random-free underrange", int'({over, under}), 1);
         vld = 1'b0; oor = 1'b0;
      end

      // directed corners
      cal_case(0, DAC_W'(-1) == 0 ? 0 : (1 << DAC_W) - 1, 1'b0, "rail targets");
      cal_case((1 << DAC_W) - 1, 0, 1'b0, "swapped rails");
      cal_case(MIDV, MIDV, 1'b0, "mid targets");
      cal_case(2000, MIDV, 1'b1, "offset unreachable");
      chk(int'(ofs_dac) == (1 << DAC_W) - 1 && int'(gain_dac) == MIDV, "R7 offset rail value",
          int'(ofs_dac), (1 << DAC_W) - 1);
      cal_case(300, -5, 1'b1, "gain unreachable");
      chk(int'(ofs_dac) == 300 && int'(gain_dac) == 0, "R7 gain rail value", int'(gain_dac), 0);
      repeat (20) @(negedge clk);
      chk(err && !dac_wr, "R7 stays stopped", int'(err), 1);

      // constrained random targets (R8 restart covered by back-to-back runs)
      for (int r = 0; r < 5; r++) begin
         cal_case(int'($urandom_range((1 << DAC_W) - 1, 0)), int'($urandom_range((1 << DAC_W) - 1, 0)),
                  1'b0, "random");
      end

      // R6 no LSB toggle at target: never accepted
      stuck_lsb = 1'b1;
      begin
         int fm, lk, db;
         run_cal(400, 600, 3000, fm, lk, db);
         chk(busy && !done && !err && !gain_ph, "R6 no toggle blocks convergence", int'(done), 0);
      end
      stuck_lsb = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && int'(ofs_dac) == MIDV, "R8 reset mid-run", int'(ofs_dac), MIDV);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule